// File: doc/BRIEF.md
# Supply Supervisor Reset Pulse Generator

This block turns two clean digital supply-monitor comparator results into system-level signals. A primary undervoltage flag forces the system reset active. After the flag clears, the reset stays active for a power-on timeout and is then released. The timeout is chosen by a two-bit select input from four durations: 50, 200, 400 or 800 ms.

A second comparator result goes straight to a fail/good output. It has no timing and no register stage. A build parameter sets the polarity of the reset output. Another parameter gives the number of clock cycles per millisecond, so every time count scales with it and a bench can run on a short time base.

On each clock edge the block samples the primary flag. The timeout counts consecutive edges at which that flag reads clear.

Top module: `sup_reset_gen`

## Requirements
- R1: When `uv_primary` is sampled high at a rising clock edge, the internal reset state is active from that edge on. It stays active for as long as the flag stays high.
- R2: Once `uv_primary` reads clear, reset stays active through the first L-1 consecutive edges at which the flag is sampled low. It releases right after the L-th such edge.
- R3: L equals T times `CYCLES_PER_MS`. T is set by `tmo_sel`: 0 gives 50, 1 gives 200, 2 gives 400 and 3 gives 800 (milliseconds).
- R4: `tmo_sel` is sampled only at the first clear edge of each timeout period. Changing it later in the period has no effect on that period's length.
- R5: If `uv_primary` rises again during a timeout, the count is discarded. A full L is counted once the flag clears again.
- R6: While `rst_n` is low, reset is active. After `rst_n` rises, the first edge with the flag clear counts as the first edge of a new timeout period.
- R7: With `ACTIVE_HIGH` = 1, `sys_rst` is 1 while reset is active and 0 otherwise. With `ACTIVE_HIGH` = 0, the levels are inverted.
- R8: `sec_good` is the combinational inverse of `uv_secondary` (1 when the secondary supply is above threshold). It has no delay and `rst_n` does not affect it.
- R9: Once released, reset stays released while `uv_primary` stays low. Changes on `tmo_sel` do not disturb it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| uv_primary | input | 1 | Primary supply below trip point |
| uv_secondary | input | 1 | Secondary supply below trip point |
| tmo_sel | input | 2 | Power-on timeout select (50/200/400/800 ms) |
| sys_rst | output | 1 | System reset, polarity set by `ACTIVE_HIGH` |
| sec_good | output | 1 | Secondary supply good, low while below threshold |

## Verification
The assertions assume that both comparator flags and the select are already synchronous to `clk`. They also assume that `CYCLES_PER_MS` is at least one, so every timeout spans at least one edge.

The stimulus meets these assumptions by changing every input on the falling clock edge only. It uses a small `CYCLES_PER_MS` so that each of the four timeouts is swept to its exact release edge. Both polarity builds are instantiated side by side and driven by the same inputs.

// File: rtl/sup_reset_gen.sv
module sup_reset_gen #(
  parameter int CYCLES_PER_MS = 50000,
  parameter bit ACTIVE_HIGH   = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       uv_primary,
  input  logic       uv_secondary,
  input  logic [1:0] tmo_sel,
  output logic       sys_rst,
  output logic       sec_good
);
  localparam int MAXC = 800 * CYCLES_PER_MS;
  localparam int CW   = $clog2(MAXC + 1);

  function automatic logic [CW-1:0] limit_of(input logic [1:0] s);
    case (s)
      2'd0:    return CW'(50 * CYCLES_PER_MS);
      2'd1:    return CW'(200 * CYCLES_PER_MS);
      2'd2:    return CW'(400 * CYCLES_PER_MS);
      default: return CW'(800 * CYCLES_PER_MS);
    endcase
  endfunction

  logic          hold;
  logic [CW-1:0] cnt;
  logic [1:0]    sel_q;
  logic          first;
  logic [CW-1:0] lim;
  logic [CW-1:0] cnt_nx;

  assign first  = (cnt == '0);
  assign lim    = limit_of(first ? tmo_sel : sel_q);
  assign cnt_nx = cnt + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold  <= 1'b1;
      cnt   <= '0;
      sel_q <= 2'd0;
    end else if (uv_primary) begin
      hold <= 1'b1;
      cnt  <= '0;
    end else if (hold) begin
      if (first) sel_q <= tmo_sel;
      cnt <= cnt_nx;
      if (cnt_nx == lim) hold <= 1'b0;
    end
  end

  assign sys_rst  = ACTIVE_HIGH ? hold : ~hold;
  assign sec_good = ~uv_secondary;
endmodule

// File: rtl/sup_reset_gen_chk.sv
module sup_reset_gen_chk #(
  parameter int CYCLES_PER_MS = 50000,
  parameter bit ACTIVE_HIGH   = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       uv_primary,
  input logic       uv_secondary,
  input logic [1:0] tmo_sel,
  input logic       sys_rst,
  input logic       sec_good
);
  localparam int MAXC = 800 * CYCLES_PER_MS;
  localparam int RW   = $clog2(MAXC + 1);

  logic          act;
  logic [RW-1:0] run;
  logic [1:0]    sel_m;
  logic [RW-1:0] lim_m;

  assign act = ACTIVE_HIGH ? sys_rst : ~sys_rst;

  always_comb begin
    case (sel_m)
      2'd0:    lim_m = RW'(50 * CYCLES_PER_MS);
      2'd1:    lim_m = RW'(200 * CYCLES_PER_MS);
      2'd2:    lim_m = RW'(400 * CYCLES_PER_MS);
      default: lim_m = RW'(800 * CYCLES_PER_MS);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= '0;
      sel_m <= 2'd0;
    end else if (uv_primary) begin
      run <= '0;
    end else begin
      if (run == '0) sel_m <= tmo_sel;
      if (run != RW'(MAXC)) run <= run + RW'(1);
    end
  end

  AST_UV_FORCES_RESET: assert property (@(posedge clk) disable iff (!rst_n) uv_primary |=> act); // R1
  AST_HOLD_IN_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n) (run < lim_m) |-> act); // R2
  AST_STAYS_RELEASED:  assert property (@(posedge clk) disable iff (!rst_n) (run >= lim_m) |-> !act); // R9
  AST_SEC_PASSTHRU:    assert property (@(posedge clk) disable iff (!rst_n) sec_good == !uv_secondary); // R8
endmodule

bind sup_reset_gen sup_reset_gen_chk #(
  .CYCLES_PER_MS(CYCLES_PER_MS),
  .ACTIVE_HIGH(ACTIVE_HIGH)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .uv_primary(uv_primary),
  .uv_secondary(uv_secondary),
  .tmo_sel(tmo_sel),
  .sys_rst(sys_rst),
  .sec_good(sec_good)
);

// File: tb/sup_reset_gen_test.sv
`timescale 1ns/1ps
module sup_reset_gen_test;
  localparam int CPM = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       uv_primary = 1'b0;
  logic       uv_secondary = 1'b0;
  logic [1:0] tmo_sel = 2'd0;
  logic       sys_rst, sys_rst_lo, sec_good, sec_good_lo;
  int         checks = 0;
  int         fails = 0;
  int         cycles = 0;

  always #10 clk = ~clk;

  sup_reset_gen #(.CYCLES_PER_MS(CPM), .ACTIVE_HIGH(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .uv_primary(uv_primary), .uv_secondary(uv_secondary),
    .tmo_sel(tmo_sel), .sys_rst(sys_rst), .sec_good(sec_good));

  sup_reset_gen #(.CYCLES_PER_MS(CPM), .ACTIVE_HIGH(1'b0)) uut_lo (
    .clk(clk), .rst_n(rst_n), .uv_primary(uv_primary), .uv_secondary(uv_secondary),
    .tmo_sel(tmo_sel), .sys_rst(sys_rst_lo), .sec_good(sec_good_lo));

  function automatic int exp_len(input logic [1:0] s);
    int ms;
    ms = (s == 2'd0) ? 50 : (s == 2'd1) ? 200 : (s == 2'd2) ? 400 : 800;
    return ms * CPM;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_rst(input bit active, input string req);
    chk(sys_rst == active, req, int'(sys_rst), int'(active));
    chk(sys_rst_lo == !active, {req, "/R7"}, int'(sys_rst_lo), int'(!active));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R6 R7: reset state
    edges(3);
    chk_rst(1'b1, "R6");
    // R8: secondary passes through, even in reset
    for (int v = 0; v < 2; v++) begin
      uv_secondary = v[0];
      #1;
      chk(sec_good == !v[0], "R8", int'(sec_good), int'(!v[0]));
      chk(sec_good_lo == !v[0], "R8", int'(sec_good_lo), int'(!v[0]));
    end
    uv_secondary = 1'b0;

    // R3 R6: timeout after block reset, each select
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      rst_n = 1'b0;
      tmo_sel = 2'(s);
      edges(2);
      chk_rst(1'b1, "R6");
      rst_n = 1'b1;
      edges(exp_len(2'(s)) - 1);
      chk_rst(1'b1, "R3_hold");
      edges(1);
      chk_rst(1'b0, "R3_release");
    end

    // R1 R2: undervoltage pulse then recovery, each select
    for (int s = 0; s < 4; s++) begin
      tmo_sel = 2'(s);
      uv_primary = 1'b1;
      edges(1);
      chk_rst(1'b1, "R1");
      edges(5);
      chk_rst(1'b1, "R1_held");
      uv_primary = 1'b0;
      edges(exp_len(2'(s)) - 1);
      chk_rst(1'b1, "R2_hold");
      edges(1);
      chk_rst(1'b0, "R2_release");
    end

    // R4: select changed mid-period is ignored
    tmo_sel = 2'd0;
    uv_primary = 1'b1;
    edges(2);
    uv_primary = 1'b0;
    edges(1);
    tmo_sel = 2'd3;
    edges(exp_len(2'd0) - 2);
    chk_rst(1'b1, "R4_hold");
    edges(1);
    chk_rst(1'b0, "R4_release");

    // R5: reassertion during timeout restarts count
    tmo_sel = 2'd0;
    uv_primary = 1'b1;
    edges(1);
    uv_primary = 1'b0;
    edges(30);
    uv_primary = 1'b1;
    edges(1);
    chk_rst(1'b1, "R5");
    uv_primary = 1'b0;
    edges(exp_len(2'd0) - 1);
    chk_rst(1'b1, "R5_hold");
    edges(1);
    chk_rst(1'b0, "R5_release");

    // R9: stays released while select changes
    for (int s = 0; s < 4; s++) begin
      tmo_sel = 2'(s);
      edges(20);
      chk_rst(1'b0, "R9");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule